// File: doc/BRIEF.md
# Modified Immediate Expander

This block turns the compressed 12-bit constant field of an instruction word into a full 32-bit operand and a shifter carry. It is placed in a decode stage next to the register-operand path. A one-bit mode input selects one of two encodings.

In the wide encoding, an 8-bit value is rotated right by an even amount. In the compact encoding, the 12-bit field is gathered from three separate places in the word. That field either replicates a byte into one of four fixed patterns, or rotates an 8-bit value whose top bit is forced to one by a 5-bit amount.

The carry-out is the incoming carry when no rotation takes place, and bit 31 of the result otherwise. A flag marks compact replication requests whose byte is zero, because the result of such a request is not defined by the encoding. All results are registered one cycle behind an input valid strobe.

Top module: `imm_expand`

## Requirements
- R1: A synchronous active-high reset clears `valid_out`, `imm_out`, `carry_out` and `unpred_out` to zero.
- R2: `valid_out` equals `valid_in` of the previous clock edge. While `valid_in` is low, `imm_out`, `carry_out` and `unpred_out` keep their last values.
- R3: With `mode_compact` = 0, `imm_out` is `insn[7:0]` zero-extended to 32 bits and rotated right by 2 × `insn[11:8]` bit positions.
- R4: With `mode_compact` = 0, `carry_out` equals `carry_in` when `insn[11:8]` is 0, and equals bit 31 of the rotated result otherwise.
- R5: With `mode_compact` = 1, the 12-bit field F is {`insn[26]`, `insn[14:12]`, `insn[7:0]`}, with `insn[26]` as F[11]. No other instruction bit affects any output.
- R6: With `mode_compact` = 1 and F[11:10] = 00, the byte B = F[7:0] is expanded by F[9:8] as follows: 00 gives 0x000000BB, 01 gives 0x00BB00BB, 10 gives 0xBB00BB00 and 11 gives 0xBBBBBBBB. In this case `carry_out` equals `carry_in`.
- R7: With `mode_compact` = 1 and F[11:10] ≠ 00, `imm_out` is the 8-bit value {1, F[6:0]} zero-extended and rotated right by F[11:7], and `carry_out` is bit 31 of that result.
- R8: `unpred_out` is 1 only when `mode_compact` = 1, F[11:10] = 00, F[9:8] ≠ 00 and F[7:0] = 0. It is 0 in every other case, including the whole of the wide encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input word is valid this cycle |
| mode_compact | input | 1 | 0 = wide rotated encoding, 1 = compact encoding |
| insn | input | 32 | Instruction word carrying the immediate field |
| carry_in | input | 1 | Current shifter carry |
| valid_out | output | 1 | Registered result is valid |
| imm_out | output | 32 | Expanded 32-bit constant |
| carry_out | output | 1 | Shifter carry after expansion |
| unpred_out | output | 1 | Compact replication of a zero byte was requested |

## Verification
Every result (`imm_out`, `carry_out`, `unpred_out` and `valid_out`) is due exactly one rising edge after the cycle in which `valid_in` is high. The bench drives each input word at a falling edge and samples the outputs at the next falling edge, which is half a period after the single capturing edge. To check the hold behaviour, the bench then drops `valid_in`, changes the word, and samples again one falling edge later. The outputs must not have moved.

// File: rtl/imm_pkg.sv
package imm_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned FIELD_W = 12;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned ROT_W   = $clog2(WORD_W);
    localparam int unsigned SEL_W   = 2;

    typedef enum logic {
        ENC_WIDE    = 1'b0,
        ENC_COMPACT = 1'b1
    } enc_mode_e;

    typedef enum logic [SEL_W-1:0] {
        REP_LOW   = 2'b00,
        REP_HALF  = 2'b01,
        REP_SHIFT = 2'b10,
        REP_ALL   = 2'b11
    } rep_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
        logic              unpred;
    } imm_result_t;

    function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] v,
                                               input logic [ROT_W-1:0]  amt);
        logic [2*WORD_W-1:0] dbl;
        dbl = {v, v} >> amt;
        return dbl[WORD_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] replicate(input logic [BYTE_W-1:0] b,
                                                    input rep_sel_e          sel);
        logic [WORD_W-1:0] r;
        case (sel)
            REP_LOW:   r = {{(WORD_W-BYTE_W){1'b0}}, b};
            REP_HALF:  r = {8'h00, b, 8'h00, b};
            REP_SHIFT: r = {b, 8'h00, b, 8'h00};
            default:   r = {b, b, b, b};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/imm_wide_expand.sv
module imm_wide_expand
    import imm_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic               carry_in,
    output imm_result_t        res
);
    localparam int unsigned AMT_W = FIELD_W - BYTE_W;

    logic [BYTE_W-1:0] base;
    logic [AMT_W-1:0]  half_amt;
    logic [ROT_W-1:0]  amt;
    logic [WORD_W-1:0] rotated;

    assign base     = field[BYTE_W-1:0];
    assign half_amt = field[FIELD_W-1:BYTE_W];
    assign amt      = {half_amt, 1'b0};
    assign rotated  = rotr({{(WORD_W-BYTE_W){1'b0}}, base}, amt);

    always_comb begin
        res.value  = rotated;
        res.unpred = 1'b0;
        if (half_amt == '0) res.carry = carry_in;
        else                res.carry = rotated[WORD_W-1];
    end
endmodule

// File: rtl/imm_compact_expand.sv
module imm_compact_expand
    import imm_pkg::*;
(
    input  logic              top_bit,
    input  logic [2:0]        mid_bits,
    input  logic [BYTE_W-1:0] low_bits,
    input  logic              carry_in,
    output imm_result_t       res
);
    logic [FIELD_W-1:0] field;
    logic               use_rep;
    rep_sel_e           sel;
    logic [WORD_W-1:0]  rep_val;
    logic [WORD_W-1:0]  rot_val;
    logic [BYTE_W-1:0]  seed;
    logic [ROT_W-1:0]   amt;

    assign field   = {top_bit, mid_bits, low_bits};
    assign use_rep = (field[FIELD_W-1:FIELD_W-2] == 2'b00);
    assign sel     = rep_sel_e'(field[BYTE_W+1:BYTE_W]);
    assign rep_val = replicate(field[BYTE_W-1:0], sel);
    assign seed    = {1'b1, field[BYTE_W-2:0]};
    assign amt     = field[FIELD_W-1:BYTE_W-1];
    assign rot_val = rotr({{(WORD_W-BYTE_W){1'b0}}, seed}, amt);

    always_comb begin
        if (use_rep) begin
            res.value  = rep_val;
            res.carry  = carry_in;
            res.unpred = (sel != REP_LOW) && (field[BYTE_W-1:0] == '0);
        end else begin
            res.value  = rot_val;
            res.carry  = rot_val[WORD_W-1];
            res.unpred = 1'b0;
        end
    end
endmodule

// File: rtl/imm_out_stage.sv
module imm_out_stage
    import imm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_in,
    input  imm_result_t res_in,
    output logic        valid_out,
    output imm_result_t res_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            res_out   <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) res_out <= res_in;
        end
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (valid_out == $past(valid_in)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(valid_in)) |-> $stable(res_out));
endmodule

// File: rtl/imm_expand.sv
module imm_expand
    import imm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic              mode_compact,
    input  logic [WORD_W-1:0] insn,
    input  logic              carry_in,
    output logic              valid_out,
    output logic [WORD_W-1:0] imm_out,
    output logic              carry_out,
    output logic              unpred_out
);
    enc_mode_e   mode;
    imm_result_t wide_res;
    imm_result_t cmp_res;
    imm_result_t sel_res;
    imm_result_t reg_res;
    logic        unused_insn_bits;

    assign mode             = enc_mode_e'(mode_compact);
    assign unused_insn_bits = ^{insn[31:27], insn[25:15]};

    imm_wide_expand u_wide (
        .field    (insn[FIELD_W-1:0]),
        .carry_in (carry_in),
        .res      (wide_res)
    );

    imm_compact_expand u_cmp (
        .top_bit  (insn[26]),
        .mid_bits (insn[14:12]),
        .low_bits (insn[BYTE_W-1:0]),
        .carry_in (carry_in),
        .res      (cmp_res)
    );

    assign sel_res = (mode == ENC_COMPACT) ? cmp_res : wide_res;

    imm_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .res_in    (sel_res),
        .valid_out (valid_out),
        .res_out   (reg_res)
    );

    assign imm_out    = reg_res.value;
    assign carry_out  = reg_res.carry;
    assign unpred_out = reg_res.unpred;

    p_wide_carry_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_in) && !$past(mode_compact) && ($past(insn[11:8]) == 4'd0))
        |-> (carry_out == $past(carry_in)));

    p_wide_zero_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_in) && !$past(mode_compact) && ($past(insn[7:0]) == 8'd0))
        |-> (imm_out == '0));

    p_rot_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_in) && $past(mode_compact) && ($past({insn[26], insn[14]}) != 2'b00))
        |-> ($countones(imm_out) >= 1));

    p_unpred_zero_r8: assert property (@(posedge clk) disable iff (rst)
        unpred_out |-> (imm_out == '0));

    p_unpred_wide_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_in) && !$past(mode_compact)) |-> !unpred_out);
endmodule

// File: tb/tb_imm_expand.sv
module tb_imm_expand;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_in;
    logic        mode_compact;
    logic [31:0] insn;
    logic        carry_in;
    logic        valid_out;
    logic [31:0] imm_out;
    logic        carry_out;
    logic        unpred_out;

    int checks = 0;
    int errors = 0;

    always #5ns clk = ~clk;

    imm_expand dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .mode_compact(mode_compact),
        .insn(insn), .carry_in(carry_in), .valid_out(valid_out),
        .imm_out(imm_out), .carry_out(carry_out), .unpred_out(unpred_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: wide encoding (R3, R4)
    task automatic ref_wide(input logic [31:0] w, input logic cin,
                            output logic [31:0] v, output logic c);
        int unsigned r;
        logic [31:0] b;
        b = {24'd0, w[7:0]};
        r = 2 * w[11:8];
        if (r == 0) begin
            v = b; c = cin;
        end else begin
            v = (b >> r) | (b << (32 - r));
            c = v[31];
        end
    endtask

    // Reference: compact encoding (R5, R6, R7, R8)
    task automatic ref_cmp(input logic [31:0] w, input logic cin,
                           output logic [31:0] v, output logic c, output logic u);
        logic [11:0] f;
        logic [31:0] b;
        int unsigned r;
        f = {w[26], w[14:12], w[7:0]};
        b = {24'd0, f[7:0]};
        u = 1'b0;
        if (f[11:10] == 2'b00) begin
            case (f[9:8])
                2'd0: v = b;
                2'd1: v = b * 32'h0001_0001;
                2'd2: v = b * 32'h0100_0100;
                default: v = b * 32'h0101_0101;
            endcase
            c = cin;
            u = (f[9:8] != 2'd0) && (f[7:0] == 8'd0);
        end else begin
            r = f[11:7];
            v = {24'd0, 1'b1, f[6:0]} << (32 - r);
            c = v[31];
        end
    endtask

    task automatic run(input logic m, input logic [31:0] w, input logic cin, input string req);
        logic [31:0] ev;
        logic ec, eu;
        logic [31:0] held;
        if (m) ref_cmp(w, cin, ev, ec, eu);
        else begin ref_wide(w, cin, ev, ec); eu = 1'b0; end
        mode_compact = m; insn = w; carry_in = cin; valid_in = 1'b1;
        @(negedge clk);
        chk("R2", "valid_out", {31'd0, valid_out}, 32'd1);
        chk(req, "imm_out", imm_out, ev);
        chk(req, "carry_out", {31'd0, carry_out}, {31'd0, ec});
        chk("R8", "unpred_out", {31'd0, unpred_out}, {31'd0, eu});
        valid_in = 1'b0;
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        logic [31:0] w;
        rst = 1'b1; valid_in = 1'b1; mode_compact = 1'b0; insn = 32'hFFFF_FFFF; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state even with valid_in high
        chk("R1", "valid_out", {31'd0, valid_out}, 32'd0);
        chk("R1", "imm_out", imm_out, 32'd0);
        chk("R1", "carry_out", {31'd0, carry_out}, 32'd0);
        chk("R1", "unpred_out", {31'd0, unpred_out}, 32'd0);
        valid_in = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R3/R4: every rotate field with several bytes and both carries
        for (int r = 0; r < 16; r++) begin
            for (int k = 0; k < 6; k++) begin
                logic [7:0] b;
                case (k)
                    0: b = 8'h00; 1: b = 8'h01; 2: b = 8'h80;
                    3: b = 8'hFF; 4: b = 8'hA5; default: b = 8'($urandom);
                endcase
                w = ($urandom & 32'hFFFF_F000) | (32'(r) << 8) | {24'd0, b};
                run(1'b0, w, k[0], (r == 0) ? "R4" : "R3");
            end
        end

        // R5/R6/R7/R8: every compact field value, noise in unrelated bits
        for (int f = 0; f < 4096; f++) begin
            logic [11:0] fv;
            fv = 12'(f);
            w = ($urandom & 32'hFBFF_0F00) | (32'(fv[11]) << 26)
                | (32'(fv[10:8]) << 12) | {24'd0, fv[7:0]};
            run(1'b1, w, f[3], (fv[11:10] == 2'b00) ? "R6" : "R7");
        end

        // R5: random words in both modes
        for (int i = 0; i < 1000; i++) begin
            run(i[0], $urandom, i[1], "R5");
        end

        // R2: outputs hold while valid_in is low
        run(1'b1, 32'h0400_10FF, 1'b0, "R7");
        held = imm_out;
        insn = 32'h0000_0012; mode_compact = 1'b0; carry_in = 1'b1;
        @(negedge clk);
        chk("R2", "valid_out low", {31'd0, valid_out}, 32'd0);
        chk("R2", "imm_out held", imm_out, held);

        // R1: reset mid-run clears outputs
        valid_in = 1'b1; rst = 1'b1;
        @(negedge clk);
        chk("R1", "valid_out after reset", {31'd0, valid_out}, 32'd0);
        chk("R1", "imm_out after reset", imm_out, 32'd0);
        rst = 1'b0; valid_in = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule